// File: doc/BRIEF.md
# Seek Distance-To-Go Counter

This block keeps the remaining distance of an actuator seek as an 11-bit count that only moves downward. The host starts a move by presenting an 8-bit length on a valid/ready load port. The length is scaled by a fixed left shift, by default times eight, and written into the count. Three 4-bit digit stages hold the count and pass a borrow from one stage to the next. After the load, the count drops by one for each accepted crossing event. The event that counts is picked from three single-cycle strobes: quarter-track crossings, track-center crossings and a self-test clock. Which one is used depends on the control inputs and on how close the seek is to its target.

The count goes back to the host, together with a flag that is high when nine or fewer counts remain. At load time the requested length is sorted into one of four seek classes. While a long seek is more than 768 counts from its target, the block asserts a saturated-velocity request, and the seek direction chooses which of its two polarity outputs carries it.

The load port never applies back-pressure: `load_ready` is held high, so a load is accepted in every cycle in which `load_valid` is high. When a load and a crossing event fall in the same cycle, the load is the one that takes effect.

Top module: `seek_dtg_counter`

## Requirements
- R1: While `rst_n` is low and after its release, `dtg` is 0, `seek_class` is 0 (short), `near_nine` is 1 and both velocity request outputs are 0.
- R2: `load_ready` is always 1. In the cycle after `load_valid` is high, `dtg` equals `load_data` shifted left by 3 bits.
- R3: If a load and any strobe come in the same cycle, the load value is written and no decrement takes place.
- R4: With `selftest_en` low, `count_en` high and `long_seek` low, `qtr_strobe` decrements the count and `ctr_strobe` has no effect.
- R5: With `selftest_en` low, `count_en` high and `long_seek` high, `ctr_strobe` decrements while `dtg` > 9 and `qtr_strobe` is ignored. Once `dtg` <= 9, the roles swap.
- R6: With `selftest_en` high, only `st_strobe` decrements and the other two strobes are ignored. With `selftest_en` low, `st_strobe` has no effect.
- R7: With `count_en` and `selftest_en` both low, none of the strobes changes the count.
- R8: A decrement at a count of 0 leaves the count at 0.
- R9: A decrement lowers `dtg` by exactly one, including when a borrow has to cross a 4-bit stage boundary (256 becomes 255).
- R10: `near_nine` is 1 exactly when `dtg` <= 9.
- R11: `max_vel_pos` is 1 when `long_seek` is high, `dtg` > 768 and `seek_dir` is 0. `max_vel_neg` is 1 under the same conditions with `seek_dir` 1. Both are 0 in every other case, and the two are never 1 together.
- R12: On each load, `seek_class` takes the class of the raw `load_data` length and keeps it until the next load. The encoding is: 0 short (0 to 2), 1 medium (3 to 8), 2 intermediate (9 to 32), 3 long (33 and above).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Host presents a new seek length |
| load_ready | output | 1 | Load is accepted (always 1) |
| load_data | input | 8 | Requested seek length in tracks |
| seek_dir | input | 1 | Seek direction, selects the velocity request polarity |
| long_seek | input | 1 | The current seek is a long seek |
| count_en | input | 1 | Enables the normal crossing sources |
| selftest_en | input | 1 | Makes the self-test clock the only source |
| qtr_strobe | input | 1 | Quarter-track crossing, single-cycle |
| ctr_strobe | input | 1 | Track-center crossing, single-cycle |
| st_strobe | input | 1 | Self-test clock tick, single-cycle |
| dtg | output | 11 | Remaining distance count |
| near_nine | output | 1 | Count is 9 or less |
| seek_class | output | 2 | Class of the last loaded length |
| max_vel_pos | output | 1 | Saturated-velocity request, direction 0 |
| max_vel_neg | output | 1 | Saturated-velocity request, direction 1 |

## Verification
The properties treat every strobe as a synchronous enable that lasts one clock. They also assume that the control levels (`long_seek`, `count_en`, `selftest_en`, `seek_dir`) only change between edges, and that a load never asks for more than the 11-bit count can hold. The bench respects all three. It drives every input a short delay after a rising edge, raises one strobe at a time for one cycle, and uses only 8-bit lengths, whose scaled value fits the count. The single exception is the load-collision test, which deliberately raises a strobe in the same cycle as a load.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef enum logic [1:0] {
    CLS_SHORT  = 2'd0,
    CLS_MEDIUM = 2'd1,
    CLS_INTER  = 2'd2,
    CLS_LONG   = 2'd3
  } seek_class_e;
endpackage

// File: rtl/dtg_digit.sv
// One down-counting stage of the distance count; it decrements when a borrow reaches it.
module dtg_digit #(
  parameter int DIG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIG_W-1:0] load_val,
  input  logic             borrow_in,
  output logic [DIG_W-1:0] q,
  output logic             zero
);
  always_ff @(posedge clk) begin
    if (!rst_n)         q <= '0;
    else if (load)      q <= load_val;
    else if (borrow_in) q <= q - 1'b1;
  end

  assign zero = (q == '0);
endmodule

// File: rtl/dtg_step_select.sv
// Picks which crossing strobe is allowed to decrement the count.
module dtg_step_select (
  input  logic selftest_en,
  input  logic count_en,
  input  logic long_seek,
  input  logic near_target,
  input  logic qtr_strobe,
  input  logic ctr_strobe,
  input  logic st_strobe,
  output logic step
);
  always_comb begin
    if (selftest_en)                     step = st_strobe;
    else if (!count_en)                  step = 1'b0;
    else if (!long_seek || near_target)  step = qtr_strobe;
    else                                 step = ctr_strobe;
  end
endmodule

// File: rtl/dtg_seek_classifier.sv
// Registers the class of the requested length at load time.
module dtg_seek_classifier
  import dtg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MED_MIN  = 3,
  parameter int INT_MIN  = 9,
  parameter int LONG_MIN = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] len,
  output seek_class_e       cls
);
  localparam int CMP_W = (DATA_W > 7) ? DATA_W + 1 : 8;

  seek_class_e cls_next;
  logic [CMP_W-1:0] len_x;

  assign len_x = CMP_W'(len);

  always_comb begin
    if (len_x >= CMP_W'(LONG_MIN))     cls_next = CLS_LONG;
    else if (len_x >= CMP_W'(INT_MIN)) cls_next = CLS_INTER;
    else if (len_x >= CMP_W'(MED_MIN)) cls_next = CLS_MEDIUM;
    else                               cls_next = CLS_SHORT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cls <= CLS_SHORT;
    else if (load) cls <= cls_next;
  end
endmodule

// File: rtl/seek_dtg_counter.sv
module seek_dtg_counter
  import dtg_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 11,
  parameter int DIG_W      = 4,
  parameter int LOAD_SHIFT = 3,
  parameter int NEAR_LIM   = 9,
  parameter int FAR_LIM    = 768,
  parameter int MED_MIN    = 3,
  parameter int INT_MIN    = 9,
  parameter int LONG_MIN   = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [DATA_W-1:0] load_data,
  input  logic              seek_dir,
  input  logic              long_seek,
  input  logic              count_en,
  input  logic              selftest_en,
  input  logic              qtr_strobe,
  input  logic              ctr_strobe,
  input  logic              st_strobe,
  output logic [CNT_W-1:0]  dtg,
  output logic              near_nine,
  output logic [1:0]        seek_class,
  output logic              max_vel_pos,
  output logic              max_vel_neg
);
  localparam int STAGES = (CNT_W + DIG_W - 1) / DIG_W;
  localparam int PAD_W  = STAGES * DIG_W;

  logic              load_fire;
  logic [PAD_W-1:0]  load_full;
  logic [PAD_W-1:0]  count_full;
  logic [STAGES-1:0] dig_zero;
  logic [STAGES-1:0] borrow_in;
  logic              step;
  logic              step_ok;
  logic              far_out;
  seek_class_e       cls;

  assign load_ready = 1'b1;
  assign load_fire  = load_valid & load_ready;
  assign load_full  = PAD_W'(load_data) << LOAD_SHIFT;

  assign near_nine = (count_full <= PAD_W'(NEAR_LIM));
  assign far_out   = (count_full > PAD_W'(FAR_LIM));

  dtg_step_select u_sel (
    .selftest_en (selftest_en),
    .count_en    (count_en),
    .long_seek   (long_seek),
    .near_target (near_nine),
    .qtr_strobe  (qtr_strobe),
    .ctr_strobe  (ctr_strobe),
    .st_strobe   (st_strobe),
    .step        (step)
  );

  // An accepted strobe is dropped at zero, so the count floors there.
  assign step_ok = step & ~(&dig_zero) & ~load_fire;

  for (genvar g = 0; g < STAGES; g++) begin : g_dig
    if (g == 0) begin : g_lsd
      assign borrow_in[g] = step_ok;
    end else begin : g_upper
      assign borrow_in[g] = step_ok & (&dig_zero[g-1:0]);
    end

    dtg_digit #(.DIG_W(DIG_W)) u_digit (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_fire),
      .load_val  (load_full[g*DIG_W +: DIG_W]),
      .borrow_in (borrow_in[g]),
      .q         (count_full[g*DIG_W +: DIG_W]),
      .zero      (dig_zero[g])
    );
  end

  assign dtg = count_full[CNT_W-1:0];

  dtg_seek_classifier #(
    .DATA_W   (DATA_W),
    .MED_MIN  (MED_MIN),
    .INT_MIN  (INT_MIN),
    .LONG_MIN (LONG_MIN)
  ) u_cls (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_fire),
    .len   (load_data),
    .cls   (cls)
  );

  assign seek_class  = cls;
  assign max_vel_pos = long_seek & far_out & ~seek_dir;
  assign max_vel_neg = long_seek & far_out &  seek_dir;
endmodule

// File: rtl/seek_dtg_checker.sv
module seek_dtg_checker #(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 11,
  parameter int LOAD_SHIFT = 3,
  parameter int NEAR_LIM   = 9,
  parameter int FAR_LIM    = 768
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_valid,
  input logic              load_ready,
  input logic [DATA_W-1:0] load_data,
  input logic              long_seek,
  input logic              count_en,
  input logic              selftest_en,
  input logic              qtr_strobe,
  input logic              ctr_strobe,
  input logic              st_strobe,
  input logic [CNT_W-1:0]  dtg,
  input logic              near_nine,
  input logic              max_vel_pos,
  input logic              max_vel_neg
);
  logic load_go;
  assign load_go = load_valid & load_ready;

  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> dtg == (CNT_W'($past(load_data)) << LOAD_SHIFT));

  assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && (qtr_strobe || ctr_strobe || st_strobe))
      |=> dtg == (CNT_W'($past(load_data)) << LOAD_SHIFT));

  assert_quarter_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_go && !selftest_en && count_en && !long_seek && !qtr_strobe) |=> $stable(dtg));

  assert_center_far_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_go && !selftest_en && count_en && long_seek && dtg > CNT_W'(NEAR_LIM) && !ctr_strobe)
      |=> $stable(dtg));

  assert_selftest_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_go && selftest_en && !st_strobe) |=> $stable(dtg));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_go && !selftest_en && !count_en) |=> $stable(dtg));

  assert_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_go && dtg == '0) |=> dtg == '0);

  assert_step_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_go |=> (dtg == $past(dtg) || dtg == CNT_W'($past(dtg) - 1'b1)));

  assert_near_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (near_nine && !load_go) |=> near_nine);

  assert_vel_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({max_vel_pos, max_vel_neg}));

  assert_vel_far_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (max_vel_pos || max_vel_neg) |-> (long_seek && dtg > CNT_W'(FAR_LIM)));
endmodule

bind seek_dtg_counter seek_dtg_checker #(
  .DATA_W     (DATA_W),
  .CNT_W      (CNT_W),
  .LOAD_SHIFT (LOAD_SHIFT),
  .NEAR_LIM   (NEAR_LIM),
  .FAR_LIM    (FAR_LIM)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_valid  (load_valid),
  .load_ready  (load_ready),
  .load_data   (load_data),
  .long_seek   (long_seek),
  .count_en    (count_en),
  .selftest_en (selftest_en),
  .qtr_strobe  (qtr_strobe),
  .ctr_strobe  (ctr_strobe),
  .st_strobe   (st_strobe),
  .dtg         (dtg),
  .near_nine   (near_nine),
  .max_vel_pos (max_vel_pos),
  .max_vel_neg (max_vel_neg)
);

// File: tb/seek_dtg_counter_tb.sv
module seek_dtg_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [7:0]  load_data = '0;
  logic        seek_dir = 1'b0;
  logic        long_seek = 1'b0;
  logic        count_en = 1'b0;
  logic        selftest_en = 1'b0;
  logic        qtr_strobe = 1'b0;
  logic        ctr_strobe = 1'b0;
  logic        st_strobe = 1'b0;
  logic [10:0] dtg;
  logic        near_nine;
  logic [1:0]  seek_class;
  logic        max_vel_pos;
  logic        max_vel_neg;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  seek_dtg_counter u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_valid  (load_valid),
    .load_ready  (load_ready),
    .load_data   (load_data),
    .seek_dir    (seek_dir),
    .long_seek   (long_seek),
    .count_en    (count_en),
    .selftest_en (selftest_en),
    .qtr_strobe  (qtr_strobe),
    .ctr_strobe  (ctr_strobe),
    .st_strobe   (st_strobe),
    .dtg         (dtg),
    .near_nine   (near_nine),
    .seek_class  (seek_class),
    .max_vel_pos (max_vel_pos),
    .max_vel_neg (max_vel_neg)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_load(input int len);
    load_valid = 1'b1;
    load_data  = 8'(len);
    tick();
    load_valid = 1'b0;
  endtask

  task automatic pulse_q();
    qtr_strobe = 1'b1; tick(); qtr_strobe = 1'b0;
  endtask

  task automatic pulse_c();
    ctr_strobe = 1'b1; tick(); ctr_strobe = 1'b0;
  endtask

  task automatic pulse_s();
    st_strobe = 1'b1; tick(); st_strobe = 1'b0;
  endtask

  task automatic set_mode(input logic st, input logic en, input logic lng);
    selftest_en = st; count_en = en; long_seek = lng;
  endtask

  task automatic t_reset();
    chk("R1 dtg in reset", dtg, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 dtg", dtg, 0);
    chk("R1 class", seek_class, 0);
    chk("R1 near", near_nine, 1);
    chk("R1 velocity", {max_vel_pos, max_vel_neg}, 0);
    chk("R2 ready", load_ready, 1);
  endtask

  task automatic t_load_class();
    set_mode(0, 0, 0);
    do_load(2);   chk("R2 load 2", dtg, 16);     chk("R12 class 2", seek_class, 0);
    do_load(3);   chk("R2 load 3", dtg, 24);     chk("R12 class 3", seek_class, 1);
    do_load(8);   chk("R12 class 8", seek_class, 1);
    do_load(9);   chk("R2 load 9", dtg, 72);     chk("R12 class 9", seek_class, 2);
    do_load(32);  chk("R12 class 32", seek_class, 2);
    do_load(33);  chk("R2 load 33", dtg, 264);   chk("R12 class 33", seek_class, 3);
    do_load(255); chk("R2 load 255", dtg, 2040); chk("R12 class 255", seek_class, 3);
    tick();       chk("R12 class held", seek_class, 3);
    do_load(0);   chk("R2 load 0", dtg, 0);      chk("R12 class 0", seek_class, 0);
  endtask

  task automatic t_short_quarter();
    set_mode(0, 1, 0);
    do_load(20);
    pulse_c(); chk("R4 center ignored", dtg, 160);
    pulse_q(); chk("R4 quarter counts", dtg, 159);
  endtask

  task automatic t_borrow();
    set_mode(0, 1, 0);
    do_load(32);  pulse_q(); chk("R9 borrow 256", dtg, 255);
    do_load(255); pulse_q(); chk("R9 step 2040", dtg, 2039);
  endtask

  task automatic t_long_far();
    set_mode(0, 1, 1);
    do_load(20);
    pulse_q(); chk("R5 far quarter ignored", dtg, 160);
    pulse_c(); chk("R5 far center counts", dtg, 159);
  endtask

  task automatic t_long_near();
    set_mode(0, 1, 1);
    do_load(2);
    for (int i = 0; i < 6; i++) pulse_c();
    chk("R5 center down to 10", dtg, 10);
    chk("R10 near at 10", near_nine, 0);
    pulse_c(); chk("R5 center reaches 9", dtg, 9);
    chk("R10 near at 9", near_nine, 1);
    pulse_c(); chk("R5 near center ignored", dtg, 9);
    pulse_q(); chk("R5 near quarter counts", dtg, 8);
  endtask

  task automatic t_selftest();
    set_mode(1, 1, 0);
    do_load(10);
    pulse_q(); chk("R6 quarter ignored", dtg, 80);
    pulse_c(); chk("R6 center ignored", dtg, 80);
    pulse_s(); chk("R6 selftest counts", dtg, 79);
    set_mode(0, 1, 0);
    pulse_s(); chk("R6 selftest off", dtg, 79);
  endtask

  task automatic t_disabled();
    set_mode(0, 0, 0);
    do_load(10);
    pulse_q(); pulse_c(); pulse_s();
    chk("R7 disabled hold", dtg, 80);
  endtask

  task automatic t_saturate();
    set_mode(0, 1, 0);
    do_load(1);
    for (int i = 0; i < 8; i++) pulse_q();
    chk("R8 reach zero", dtg, 0);
    pulse_q(); chk("R8 floor", dtg, 0);
  endtask

  task automatic t_load_wins();
    set_mode(0, 1, 0);
    do_load(50);
    qtr_strobe = 1'b1;
    do_load(5);
    qtr_strobe = 1'b0;
    chk("R3 load wins", dtg, 40);
  endtask

  task automatic t_maxvel();
    set_mode(0, 1, 1);
    seek_dir = 1'b0;
    do_load(97);
    chk("R11 pos far", max_vel_pos, 1);
    chk("R11 neg far", max_vel_neg, 0);
    seek_dir = 1'b1; #1;
    chk("R11 neg dir1", max_vel_neg, 1);
    chk("R11 pos dir1", max_vel_pos, 0);
    for (int i = 0; i < 7; i++) pulse_c();
    chk("R11 at 769", max_vel_neg, 1);
    pulse_c();
    chk("R11 dtg 768", dtg, 768);
    chk("R11 off at 768", {max_vel_pos, max_vel_neg}, 0);
    long_seek = 1'b0;
    do_load(200);
    chk("R11 not long", {max_vel_pos, max_vel_neg}, 0);
    seek_dir = 1'b0;
  endtask

  initial begin
    #4_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    t_load_class();
    t_short_quarter();
    t_borrow();
    t_long_far();
    t_long_near();
    t_selftest();
    t_disabled();
    t_saturate();
    t_load_wins();
    t_maxvel();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule